// File: doc/BRIEF.md
# Stereo Disparity Data Cost Unit

This block turns a pair of rectified grey-level scan lines into the raw matching costs that a stereo disparity search consumes. A left line and a right line arrive together, one pixel pair per clock, with a strobe marking the first pair of a line. Once a full line is held in registers, the block walks every left pixel in column order. For each column it produces one cost per candidate disparity, in ascending disparity order.

Each cost compares the left pixel at column c with the right pixel at column c+d. The absolute difference is scaled by a constant weight, which is built from shifts and adds. The scaled value saturates at the largest value the cost field can hold and is then clipped to a ceiling. Clipping at the ceiling keeps occluded or badly lit pixels from dominating later smoothing stages. The right-line candidates come from a window register that is reloaded for each column and shifts by one place per disparity. A candidate that lies past the right end of the line gets the ceiling cost.

Loading and cost generation alternate. While costs are being produced, the pixel input reports not ready, and a downstream consumer paces the cost stream with a valid/ready handshake.

Top module: `sdc_cost_unit`

## Requirements
- R1: While reset is held and right after it, `px_ready` is 1 and `cost_valid` is 0.
- R2: A pixel pair accepted with `px_sol` high is stored at column 0. Each following accepted pair without `px_sol` goes to the next column. When column LINE_W-1 has been written, `px_ready` is 0 and `cost_valid` is 1 from the next clock.
- R3: Pairs offered before any start-of-line strobe are ignored. A strobe that arrives part way through a line restarts that line at column 0.
- R4: Costs leave in column order 0..LINE_W-1. Within each column they leave in disparity order 0..NDISP-1, and every accepted transfer advances exactly one step.
- R5: When c+d <= LINE_W-1, `cost_val` = min(WEIGHT*|right[c+d] - left[c]|, CEIL). The defaults are WEIGHT 4 and CEIL 60.
- R6: When c+d >= LINE_W, `cost_val` equals CEIL whatever the pixel values are.
- R7: The weighted difference saturates at 2^COST_W-1 before the clip is applied. With WEIGHT 5 and CEIL 1023, a difference of 255 yields 1023.
- R8: While `cost_valid` is high and `cost_ready` is low, `cost_col`, `cost_disp` and `cost_val` hold their values.
- R9: After the transfer of column LINE_W-1 at disparity NDISP-1, `px_ready` is 1 and `cost_valid` is 0 from the next clock. While costs are pending, offered pixel pairs, strobes included, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| px_valid | input | 1 | A pixel pair is offered |
| px_sol | input | 1 | The offered pair is the first of a line |
| px_left | input | PIX_W | Left-image grey value |
| px_right | input | PIX_W | Right-image grey value |
| px_ready | output | 1 | The block is accepting pixel pairs |
| cost_valid | output | 1 | A cost is presented |
| cost_ready | input | 1 | The consumer takes the presented cost |
| cost_col | output | $clog2(LINE_W) | Left-pixel column of the cost |
| cost_disp | output | $clog2(NDISP) | Disparity of the cost |
| cost_val | output | COST_W | Weighted, saturated, clipped cost |

## Verification
Two events can land in the same clock: the consumer's stall, and a step that would either move the disparity window or reload it for the next column. The bench drops `cost_ready` at random, so stalls fall on the last disparity of a column and on the final transfer of a line. It also keeps offering pixel pairs with strobes throughout the cost phase. The reference model holds the expected stream in a queue that is popped only on a transfer. Each clock the bench checks that a stalled output is held with no column or disparity skipped or repeated, and that no stray pixel pair or strobe reaches the stored line.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

   typedef enum logic {
      PH_LOAD = 1'b0,
      PH_COST = 1'b1
   } sdc_phase_e;

   function automatic int sdc_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sdc_line_store.sv
module sdc_line_store #(
   parameter int PIX_W  = 8,
   parameter int LINE_W = 64
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            accept_en,
   input  logic                            px_valid,
   input  logic                            px_sol,
   input  logic [PIX_W-1:0]                px_left,
   input  logic [PIX_W-1:0]                px_right,
   output logic                            line_done,
   output logic [LINE_W-1:0][PIX_W-1:0]    left_line,
   output logic [LINE_W-1:0][PIX_W-1:0]    right_line
);

   localparam int IDX_W = $clog2(LINE_W);

   logic [IDX_W-1:0] wr_idx;
   logic             armed;
   logic             take;
   logic             store;
   logic [IDX_W-1:0] wr_at;

   assign take      = accept_en & px_valid;
   assign wr_at     = px_sol ? '0 : wr_idx;
   assign store     = take & (px_sol | armed);
   assign line_done = store && (wr_at == IDX_W'(LINE_W - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed  <= 1'b0;
         wr_idx <= '0;
      end else if (store) begin
         if (line_done) begin
            armed  <= 1'b0;
            wr_idx <= '0;
         end else begin
            armed  <= 1'b1;
            wr_idx <= wr_at + 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (store) begin
         left_line[wr_at]  <= px_left;
         right_line[wr_at] <= px_right;
      end
   end

   // R2
   wr_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> ((wr_idx != '0) && (int'(wr_idx) < LINE_W)));

endmodule

// File: rtl/sdc_shift_window.sv
module sdc_shift_window #(
   parameter int PIX_W  = 8,
   parameter int LINE_W = 64,
   parameter int NDISP  = 32
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            ld,
   input  logic [$clog2(LINE_W)-1:0]       ld_col,
   input  logic                            step,
   input  logic [LINE_W-1:0][PIX_W-1:0]    right_line,
   output logic [PIX_W-1:0]                head_px,
   output logic                            head_ok
);

   localparam int COL_W = $clog2(LINE_W);
   localparam int SRC_W = COL_W + 1;

   logic [NDISP-1:0][PIX_W-1:0] win;
   logic [NDISP-1:0]            ok;
   logic [NDISP-1:0][PIX_W-1:0] fill_px;
   logic [NDISP-1:0]            fill_ok;

   for (genvar k = 0; k < NDISP; k++) begin : g_fill
      logic [SRC_W-1:0] src;
      assign src        = SRC_W'(ld_col) + SRC_W'(k);
      assign fill_ok[k] = (src < SRC_W'(LINE_W));
      assign fill_px[k] = fill_ok[k] ? right_line[src[COL_W-1:0]] : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win <= '0;
         ok  <= '0;
      end else if (ld) begin
         win <= fill_px;
         ok  <= fill_ok;
      end else if (step) begin
         for (int k = 0; k < NDISP - 1; k++) begin
            win[k] <= win[k+1];
            ok[k]  <= ok[k+1];
         end
         win[NDISP-1] <= '0;
         ok[NDISP-1]  <= 1'b0;
      end
   end

   assign head_px = win[0];
   assign head_ok = ok[0];

   // R6
   tail_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !ld) |=> !ok[NDISP-1]);

endmodule

// File: rtl/sdc_cost_calc.sv
module sdc_cost_calc #(
   parameter int PIX_W  = 8,
   parameter int COST_W = 10,
   parameter int WEIGHT = 4,
   parameter int CEIL   = 60
) (
   input  logic [PIX_W-1:0]  px_l,
   input  logic [PIX_W-1:0]  px_r,
   input  logic              in_line,
   output logic [COST_W-1:0] cost
);

   localparam int W_BITS   = $clog2(WEIGHT + 1);
   localparam int PROD_W   = PIX_W + W_BITS;
   localparam int CMP_W    = sdc_pkg::sdc_max(PROD_W, COST_W) + 1;
   localparam int MAX_COST = (1 << COST_W) - 1;

   logic [PIX_W-1:0]  absdiff;
   logic [PROD_W-1:0] prod;
   logic [CMP_W-1:0]  prod_w;
   logic [COST_W-1:0] sat;
   logic [COST_W-1:0] clip;

   assign absdiff = (px_r > px_l) ? (px_r - px_l) : (px_l - px_r);

   if ((WEIGHT & (WEIGHT - 1)) == 0) begin : g_pow2
      assign prod = PROD_W'(absdiff) << $clog2(WEIGHT);
   end else begin : g_shift_add
      logic [PROD_W-1:0] term [W_BITS];
      for (genvar i = 0; i < W_BITS; i++) begin : g_term
         if (((WEIGHT >> i) & 1) != 0) begin : g_on
            assign term[i] = PROD_W'(absdiff) << i;
         end else begin : g_off
            assign term[i] = '0;
         end
      end
      always_comb begin
         prod = '0;
         for (int i = 0; i < W_BITS; i++) prod = prod + term[i];
      end
   end

   assign prod_w = CMP_W'(prod);
   assign sat    = (prod_w > CMP_W'(MAX_COST)) ? COST_W'(MAX_COST) : prod_w[COST_W-1:0];
   assign clip   = (sat > COST_W'(CEIL)) ? COST_W'(CEIL) : sat;
   assign cost   = in_line ? clip : COST_W'(CEIL);

endmodule

// File: rtl/sdc_cost_unit.sv
module sdc_cost_unit #(
   parameter int PIX_W  = 8,
   parameter int LINE_W = 64,
   parameter int NDISP  = 32,
   parameter int COST_W = 10,
   parameter int WEIGHT = 4,
   parameter int CEIL   = 60
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      px_valid,
   input  logic                      px_sol,
   input  logic [PIX_W-1:0]          px_left,
   input  logic [PIX_W-1:0]          px_right,
   output logic                      px_ready,
   output logic                      cost_valid,
   input  logic                      cost_ready,
   output logic [$clog2(LINE_W)-1:0] cost_col,
   output logic [$clog2(NDISP)-1:0]  cost_disp,
   output logic [COST_W-1:0]         cost_val
);

   import sdc_pkg::*;

   localparam int COL_W  = $clog2(LINE_W);
   localparam int DISP_W = $clog2(NDISP);

   if (LINE_W < 2 || NDISP < 2 || NDISP > LINE_W) begin : g_bad_geometry
      initial $error("sdc_cost_unit: need 2 <= NDISP <= LINE_W");
   end
   if (WEIGHT < 1 || CEIL < 0 || CEIL > (1 << COST_W) - 1) begin : g_bad_cost
      initial $error("sdc_cost_unit: WEIGHT >= 1 and CEIL within COST_W");
   end

   sdc_phase_e        phase;
   logic [COL_W-1:0]  col;
   logic [DISP_W-1:0] disp;
   logic              line_done;
   logic              fire;
   logic              last_d;
   logic              last_c;
   logic              win_ld;
   logic              win_step;
   logic [COL_W-1:0]  win_col;
   logic [PIX_W-1:0]  head_px;
   logic              head_ok;
   logic [LINE_W-1:0][PIX_W-1:0] left_line;
   logic [LINE_W-1:0][PIX_W-1:0] right_line;

   assign px_ready   = (phase == PH_LOAD);
   assign cost_valid = (phase == PH_COST);
   assign fire       = cost_valid & cost_ready;
   assign last_d     = (disp == DISP_W'(NDISP - 1));
   assign last_c     = (col == COL_W'(LINE_W - 1));
   assign win_ld     = line_done | (fire & last_d & ~last_c);
   assign win_col    = line_done ? '0 : col + 1'b1;
   assign win_step   = fire & ~last_d;

   sdc_line_store #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept_en  (px_ready),
      .px_valid   (px_valid),
      .px_sol     (px_sol),
      .px_left    (px_left),
      .px_right   (px_right),
      .line_done  (line_done),
      .left_line  (left_line),
      .right_line (right_line)
   );

   sdc_shift_window #(.PIX_W(PIX_W), .LINE_W(LINE_W), .NDISP(NDISP)) u_window (
      .clk        (clk),
      .rst_n      (rst_n),
      .ld         (win_ld),
      .ld_col     (win_col),
      .step       (win_step),
      .right_line (right_line),
      .head_px    (head_px),
      .head_ok    (head_ok)
   );

   sdc_cost_calc #(.PIX_W(PIX_W), .COST_W(COST_W), .WEIGHT(WEIGHT), .CEIL(CEIL)) u_calc (
      .px_l    (left_line[col]),
      .px_r    (head_px),
      .in_line (head_ok),
      .cost    (cost_val)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_LOAD;
         col   <= '0;
         disp  <= '0;
      end else if (line_done) begin
         phase <= PH_COST;
         col   <= '0;
         disp  <= '0;
      end else if (fire) begin
         if (last_d) begin
            disp <= '0;
            if (last_c) begin
               phase <= PH_LOAD;
               col   <= '0;
            end else begin
               col <= col + 1'b1;
            end
         end else begin
            disp <= disp + 1'b1;
         end
      end
   end

   assign cost_col  = col;
   assign cost_disp = disp;

   // R8
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cost_valid && !cost_ready) |=> (cost_valid && $stable(cost_col)
                                       && $stable(cost_disp) && $stable(cost_val)));

   // R4
   disp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !last_d) |=> ((cost_disp == $past(cost_disp) + 1'b1) && $stable(cost_col)));

   // R4
   col_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && last_d && !last_c) |=> ((cost_disp == '0) && (cost_col == $past(cost_col) + 1'b1)));

   // R9
   line_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && last_d && last_c) |=> (px_ready && !cost_valid));

   // R5
   ceiling_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cost_valid |-> (int'(cost_val) <= CEIL));

   // R6
   edge_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cost_valid && (int'(cost_col) + int'(cost_disp) >= LINE_W)) |-> (int'(cost_val) == CEIL));

endmodule

// File: tb/tb_sdc_cost_unit.sv
module tb_sdc_cost_unit;

   localparam int LW = 16;
   localparam int ND = 8;
   localparam int PW = 8;
   localparam int CW = 10;
   localparam int COLW = $clog2(LW);
   localparam int DW = $clog2(ND);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic px_valid = 1'b0, px_sol = 1'b0, cost_ready = 1'b0;
   logic [PW-1:0] px_left = '0, px_right = '0;
   logic px_ready, cost_valid, s_px_ready, s_cost_valid;
   logic [COLW-1:0] cost_col, s_cost_col;
   logic [DW-1:0] cost_disp, s_cost_disp;
   logic [CW-1:0] cost_val, s_cost_val;

   always #10 clk = ~clk;

   sdc_cost_unit #(.PIX_W(PW), .LINE_W(LW), .NDISP(ND), .COST_W(CW), .WEIGHT(4), .CEIL(60)) dut (
      .clk(clk), .rst_n(rst_n), .px_valid(px_valid), .px_sol(px_sol), .px_left(px_left),
      .px_right(px_right), .px_ready(px_ready), .cost_valid(cost_valid), .cost_ready(cost_ready),
      .cost_col(cost_col), .cost_disp(cost_disp), .cost_val(cost_val));

   sdc_cost_unit #(.PIX_W(PW), .LINE_W(LW), .NDISP(ND), .COST_W(CW), .WEIGHT(5), .CEIL(1023)) dut_sat (
      .clk(clk), .rst_n(rst_n), .px_valid(px_valid), .px_sol(px_sol), .px_left(px_left),
      .px_right(px_right), .px_ready(s_px_ready), .cost_valid(s_cost_valid), .cost_ready(cost_ready),
      .cost_col(s_cost_col), .cost_disp(s_cost_disp), .cost_val(s_cost_val));

   typedef struct { int col; int disp; int ca; int cb; } exp_t;
   exp_t q[$];
   int lref[LW];
   int rref[LW];
   int widx = 0;
   bit armed = 0;
   int n_cmp = 0, n_bad = 0, cycles = 0;
   string ph = "reset";
   bit held = 0;
   int prev_col, prev_disp, prev_cost;

   task automatic chk(string tag, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s [%s] actual %0d expected %0d", tag, ph, act, exp);
      end
   endtask

   function automatic int ref_cost(int l, int r, bit ok, int w, int ceil);
      int p;
      if (!ok) return ceil;
      p = w * ((l > r) ? l - r : r - l);
      if (p > 1023) p = 1023;
      return (p < ceil) ? p : ceil;
   endfunction

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         n_bad++;
         $display("FAIL watchdog expired [%s]", ph);
         summary();
         $finish;
      end
   end

   // One clock: drive after the falling edge, check the outputs, then advance the model.
   task automatic cyc(bit v, bit s, int l, int r, bit rdy);
      bit mready;
      px_valid = v; px_sol = s; px_left = PW'(l); px_right = PW'(r); cost_ready = rdy;
      #1;
      mready = (q.size() == 0);
      chk("R9 px_ready", int'(px_ready), int'(mready));
      chk("R2 cost_valid", int'(cost_valid), int'(!mready));
      chk("R7 sat cost_valid", int'(s_cost_valid), int'(!mready));
      if (held) begin
         chk("R8 held col", int'(cost_col), prev_col);
         chk("R8 held disp", int'(cost_disp), prev_disp);
         chk("R8 held cost", int'(cost_val), prev_cost);
      end
      if (!mready) begin
         chk("R4 col", int'(cost_col), q[0].col);
         chk("R4 disp", int'(cost_disp), q[0].disp);
         if (q[0].col + q[0].disp >= LW) chk("R6 edge cost", int'(cost_val), q[0].ca);
         else chk("R5 cost", int'(cost_val), q[0].ca);
         chk("R7 saturated cost", int'(s_cost_val), q[0].cb);
      end
      held = !mready && !rdy;
      prev_col = int'(cost_col); prev_disp = int'(cost_disp); prev_cost = int'(cost_val);
      if (!mready && rdy) void'(q.pop_front());
      if (mready && v) begin
         if (s) begin widx = 0; armed = 1; end
         if (armed) begin
            lref[widx] = l; rref[widx] = r; widx++;
            if (widx == LW) begin
               armed = 0; widx = 0;
               for (int c = 0; c < LW; c++)
                  for (int d = 0; d < ND; d++) begin
                     exp_t e;
                     bit ok = (c + d < LW);
                     e.col = c; e.disp = d;
                     e.ca = ref_cost(lref[c], ok ? rref[c+d] : 0, ok, 4, 60);
                     e.cb = ref_cost(lref[c], ok ? rref[c+d] : 0, ok, 5, 1023);
                     q.push_back(e);
                  end
            end
         end
      end
      @(negedge clk);
   endtask

   // mode 0 random, 1 left 0 / right 255, 2 equal, 3 small ramp of differences
   task automatic feed_line(int mode, bit gaps);
      for (int i = 0; i < LW; i++) begin
         int l, r;
         case (mode)
            1: begin l = 0; r = 255; end
            2: begin l = 77; r = 77; end
            3: begin l = 100; r = 100 + (i % 16); end
            default: begin l = $urandom % 256; r = $urandom % 256; end
         endcase
         if (gaps) while ($urandom % 3 == 0) cyc(0, 0, 0, 0, 1);
         cyc(1, i == 0, l, r, 1);
      end
   endtask

   task automatic drain(bit rnd, bit noise);
      for (int n = 0; n < 4000 && q.size() > 0; n++)
         cyc(noise, noise && ($urandom % 2 == 0), $urandom % 256, $urandom % 256,
             rnd ? ($urandom % 4 != 0) : 1'b1);
      cyc(0, 0, 0, 0, 1);
   endtask

   initial begin
      @(negedge clk);
      // R1: values while reset is held
      for (int i = 0; i < 3; i++) begin
         #1;
         chk("R1 px_ready in reset", int'(px_ready), 1);
         chk("R1 cost_valid in reset", int'(cost_valid), 0);
         @(negedge clk);
      end
      rst_n = 1'b1;
      ph = "R1 after reset";
      cyc(0, 0, 0, 0, 0);

      ph = "R3 pairs before strobe";
      for (int i = 0; i < 5; i++) cyc(1, 0, 10 * i, 200, 1);
      ph = "R5 random line";
      feed_line(0, 0);
      drain(0, 0);

      ph = "R3 restart mid line";
      for (int i = 0; i < 6; i++) cyc(1, i == 0, 255, 0, 1);
      feed_line(0, 1);
      ph = "R8 R9 stalls with noise";
      drain(1, 1);

      ph = "R7 extremes";
      feed_line(1, 0);
      drain(1, 0);
      ph = "R5 equal pixels";
      feed_line(2, 0);
      drain(0, 1);
      ph = "R5 ceiling boundary";
      feed_line(3, 1);
      drain(1, 1);
      for (int k = 0; k < 3; k++) begin
         ph = "R4 R6 random lines";
         feed_line(0, 1);
         drain(1, 1);
      end
      summary();
      $finish;
   end

endmodule